// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable integer N = B·P + A and emits one single-cycle pulse every N input cycles. The pulse is intended as the feedback input of a phase detector. The block has three parts:

- A dual-modulus prescaler that counts either P or P+1 input cycles per output strobe. It is modelled as a synchronous digital counter.
- A 6-bit swallow counter that holds the prescaler at P+1 for the first A strobes of each output period.
- A 13-bit main counter that counts B strobes and marks the end of the period.

The modulus pair is chosen by a 2-bit select code. A, B and the select code come from a holding register outside the block. They are sampled only at an output-period boundary, so a period of mixed length is never produced. The block rejects settings with B < A or B < 3: it raises an error flag and keeps its output low until a legal setting is presented.

Top module: `pswal_divider`

## Requirements
- R1: While `rst` is high, `fb_pulse` is low, and `cfg_err` is low for a legal setting. The first pulse rises exactly N cycles after the last clock edge at which `rst` was high.
- R2: With legal settings, consecutive rising edges of `fb_pulse` are exactly B·P + A input cycles apart. `mod_sel` selects P as follows: 00 gives P=8, 01 gives P=16, 10 gives P=32, 11 gives P=64. One example is A=63, B=891, P=32, which gives 28575 cycles.
- R3: Every output pulse is high for exactly one input cycle.
- R4: A may take any value from 0 to 63, including A = B. With A = B, every prescaler cycle of the period is P+1 long.
- R5: A setting with B < A or B < 3 drives `cfg_err` high. While the flag is high, `fb_pulse` stays low. The period in progress when the illegal setting is taken still completes with its pulse.
- R6: The values on `mod_sel`, `swallow_cnt` and `main_cnt` at the clock edge that raises `fb_pulse` govern the next period. Changes at any other time do not alter the period in progress.
- R7: While `cfg_err` is high, the inputs are sampled every cycle. When a legal setting is sampled, the flag clears on that edge and the next pulse rises N cycles later.
- R8: For a 2.4 GHz input, the prescaler output rate measured from the output period (3·fin/N with B=3, A=0) is at most 300 MHz for P=8 and at most 325 MHz for the larger moduli.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous reset, active high; the setting is sampled during it |
| mod_sel | input | 2 | Prescaler modulus pair select |
| swallow_cnt | input | 6 | A value from the holding register |
| main_cnt | input | 13 | B value from the holding register |
| fb_pulse | output | 1 | One-cycle pulse per N input cycles |
| cfg_err | output | 1 | High while the active setting is illegal |

## Verification
Two functions can fall on the same edge.

- With A = B, the swallow counter empties on the same prescaler strobe that ends the period. The bench provokes this with several A = B settings and judges it by the measured period A·(P+1).
- Sampling of a new setting can coincide with the terminal edge itself. The bench drives new values exactly one cycle before a pulse is due, and also a few cycles after a pulse. It then checks that only the first case changes the very next period, and that the period already running keeps its old length in both cases.

// File: rtl/pswal_pkg.sv
package pswal_pkg;

   // Prescaler select encoding; the lower modulus doubles per step.
   typedef enum logic [1:0] {
      PSEL_P8  = 2'b00,
      PSEL_P16 = 2'b01,
      PSEL_P32 = 2'b10,
      PSEL_P64 = 2'b11
   } psel_e;

   localparam int unsigned MIN_MAIN_COUNT = 3;

endpackage

// File: rtl/pswal_prescaler.sv
module pswal_prescaler #(
   parameter  int P_MIN = 8,
   parameter  int N_SEL = 4,
   localparam int SEL_W = $clog2(N_SEL),
   localparam int P_TOP = P_MIN << (N_SEL - 1),
   localparam int PC_W  = $clog2(P_TOP + 2)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic [SEL_W-1:0] sel,
   input  logic             swallow,
   output logic             strobe
);

   logic [PC_W-1:0] mod_tab [N_SEL];
   logic [PC_W-1:0] mod_now;
   logic [PC_W-1:0] pc;
   logic            wrap;

   initial begin
      assert (P_MIN >= 2) else $error("prescaler lower modulus too small");
      assert (N_SEL == (1 << SEL_W)) else $error("select count must be a power of two");
   end

   // Modulus table: lower modulus doubles per select step.
   for (genvar i = 0; i < N_SEL; i++) begin : g_mod
      assign mod_tab[i] = PC_W'(P_MIN << i);
   end

   assign mod_now = mod_tab[sel] + PC_W'(swallow);
   assign wrap    = (pc == mod_now - PC_W'(1));
   assign strobe  = run & wrap;

   always_ff @(posedge clk) begin
      if (rst || !run)
         pc <= '0;
      else if (wrap)
         pc <= '0;
      else
         pc <= pc + PC_W'(1);
   end

   // R2: the phase counter never runs past the selected modulus
   p_pc_range_r2: assert property (@(posedge clk) disable iff (rst)
      run |-> (pc < mod_now));

endmodule

// File: rtl/pswal_downcnt.sv
module pswal_downcnt #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         dec,
   output logic [W-1:0] cnt
);

   initial begin
      assert (W >= 2) else $error("down counter too narrow");
   end

   always_ff @(posedge clk) begin
      if (load)
         cnt <= load_val;
      else if (dec && (cnt != '0))
         cnt <= cnt - W'(1);
   end

endmodule

// File: rtl/pswal_divider.sv
module pswal_divider #(
   parameter  int A_W     = 6,
   parameter  int B_W     = 13,
   parameter  int P_MIN   = 8,
   parameter  int N_SEL   = 4,
   localparam int SEL_W   = $clog2(N_SEL)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SEL_W-1:0] mod_sel,
   input  logic [A_W-1:0]   swallow_cnt,
   input  logic [B_W-1:0]   main_cnt,
   output logic             fb_pulse,
   output logic             cfg_err
);
   import pswal_pkg::*;

   logic             in_ok;
   logic             take;
   logic             run;
   logic             strobe;
   logic             term;
   logic [SEL_W-1:0] sel_q;
   logic             err_q;
   logic             pulse_q;
   logic [A_W-1:0]   a_cnt;
   logic [B_W-1:0]   b_cnt;

   initial begin
      assert (B_W > A_W) else $error("main counter must be wider than swallow counter");
      assert (N_SEL >= 2) else $error("need at least two modulus pairs");
      assert (B_W > $clog2(MIN_MAIN_COUNT)) else $error("main counter cannot hold floor");
   end

   // Setting legality: B at least A and at least the floor.
   assign in_ok = (main_cnt >= B_W'(swallow_cnt)) &&
                  (main_cnt >= B_W'(MIN_MAIN_COUNT));

   assign run  = !rst && !err_q;
   assign term = strobe && (b_cnt == B_W'(1));
   // Inputs are taken at reset, at each period boundary, and every cycle while faulted.
   assign take = rst || term || err_q;

   always_ff @(posedge clk) begin
      if (take) begin
         sel_q <= mod_sel;
         err_q <= !in_ok;
      end
      pulse_q <= rst ? 1'b0 : term;
   end

   pswal_prescaler #(
      .P_MIN (P_MIN),
      .N_SEL (N_SEL)
   ) u_psc (
      .clk     (clk),
      .rst     (rst),
      .run     (run),
      .sel     (sel_q),
      .swallow (a_cnt != '0),
      .strobe  (strobe)
   );

   pswal_downcnt #(.W(A_W)) u_swallow (
      .clk      (clk),
      .load     (take),
      .load_val (swallow_cnt),
      .dec      (strobe),
      .cnt      (a_cnt)
   );

   pswal_downcnt #(.W(B_W)) u_main (
      .clk      (clk),
      .load     (take),
      .load_val (main_cnt),
      .dec      (strobe),
      .cnt      (b_cnt)
   );

   assign fb_pulse = pulse_q;
   assign cfg_err  = err_q;

   // R3: pulse never lasts two cycles
   p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
      fb_pulse |=> !fb_pulse);

   // R5: no pulse while a faulted setting was active on the previous edge
   p_err_quiet_r5: assert property (@(posedge clk) disable iff (rst)
      $past(err_q) |-> !fb_pulse);

   // R6: a pulse coincides with a fresh load of the values present at its edge
   p_boundary_load_r6: assert property (@(posedge clk) disable iff (rst)
      fb_pulse |-> (sel_q == $past(mod_sel)) && (b_cnt == $past(main_cnt)));

   // R4: swallow count never exceeds remaining main count in legal operation
   p_a_within_b_r4: assert property (@(posedge clk) disable iff (rst)
      !err_q |-> (B_W'(a_cnt) <= b_cnt));

   // R7: an illegal sample keeps the flag up
   p_err_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (err_q && !in_ok) |=> err_q);

endmodule

// File: tb/tb_pswal_divider.sv
module tb_pswal_divider;

   logic        clk = 1'b0;
   logic        rst;
   logic [1:0]  msel;
   logic [5:0]  acnt;
   logic [12:0] bcnt;
   logic        fbp;
   logic        err;

   int cyc  = 0;
   int nvec = 0;
   int nbad = 0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pswal_divider dut (
      .clk         (clk),
      .rst         (rst),
      .mod_sel     (msel),
      .swallow_cnt (acnt),
      .main_cnt    (bcnt),
      .fb_pulse    (fbp),
      .cfg_err     (err)
   );

   function automatic int nexp(int s, int a, int b);
      return b * (8 << s) + a;
   endfunction

   task automatic chk(bit ok, string tag, int act, int expv);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
      end
   endtask

   task automatic drive(int s, int a, int b);
      msel = 2'(s);
      acnt = 6'(a);
      bcnt = 13'(b);
   endtask

   // Returns the cycle stamp of the next pulse, then checks its width (R3).
   task automatic next_pulse(output int t);
      do @(negedge clk); while (fbp !== 1'b1);
      t = cyc;
      @(negedge clk);
      chk(fbp === 1'b0, "R3 pulse width", int'(fbp), 0);
   endtask

   task automatic wait_until(int target);
      while (cyc < target) @(negedge clk);
   endtask

   initial begin
      repeat (195000) @(posedge clk);
      nbad++;
      nvec++;
      $display("FAIL R2 watchdog: cycles %0d expected finish before %0d", cyc, 195000);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      int t0, t, t1, t2, ta, tb, tc, td, te;
      int pa [5] = '{0, 2, 3, 7, 63};
      int pb [5] = '{3, 3, 3, 9, 63};
      bit seen;

      // R1: reset behaviour and first period
      rst = 1'b1;
      drive(0, 0, 3);
      repeat (3) begin
         @(negedge clk);
         chk(fbp === 1'b0, "R1 output low in reset", int'(fbp), 0);
         chk(err === 1'b0, "R1 flag low in reset", int'(err), 0);
      end
      rst = 1'b0;
      t0 = cyc;
      next_pulse(t);
      chk(t - t0 == 24, "R1 first period after reset", t - t0, 24);

      // R2 / R4 / R8: sweep every select code over several A,B pairs
      for (int s = 0; s < 4; s++) begin
         for (int i = 0; i < 5; i++) begin
            drive(s, pa[i], pb[i]);
            next_pulse(t1);
            next_pulse(t2);
            chk(t2 - t1 == nexp(s, pa[i], pb[i]),
                (pa[i] == pb[i]) ? "R4 period with A=B" : "R2 period",
                t2 - t1, nexp(s, pa[i], pb[i]));
            chk(err === 1'b0, "R2 flag low for legal setting", int'(err), 0);
            if (i == 0) begin
               int rate = (2400 * 3) / (t2 - t1);
               int lim  = (s == 0) ? 300 : 325;
               chk(rate <= lim, "R8 prescaler output rate MHz", rate, lim);
            end
         end
      end

      // R6: mid-period change ignored; change one cycle before pulse applies next
      drive(1, 4, 10);
      next_pulse(ta);
      wait_until(ta + 2);
      drive(2, 1, 5);
      next_pulse(tb);
      chk(tb - ta == 164, "R6 mid-period change ignored", tb - ta, 164);
      wait_until(tb + 161 - 1);
      drive(0, 6, 12);
      next_pulse(tc);
      chk(tc - tb == 161, "R6 period after boundary take", tc - tb, 161);
      next_pulse(td);
      chk(td - tc == 102, "R6 values at pulse edge govern next period", td - tc, 102);

      // R5: illegal settings (B below floor, then B below A)
      drive(0, 0, 2);
      next_pulse(t);
      chk(err === 1'b1, "R5 flag after B below floor", int'(err), 1);
      seen = 1'b0;
      repeat (300) begin
         @(negedge clk);
         if (fbp !== 1'b0 || err !== 1'b1) seen = 1'b1;
      end
      chk(!seen, "R5 output held low while flagged", int'(seen), 0);
      drive(0, 5, 4);
      repeat (5) @(negedge clk);
      chk(err === 1'b1, "R5 flag for B below A", int'(err), 1);
      chk(fbp === 1'b0, "R5 output low for B below A", int'(fbp), 0);

      // R7: recovery on a legal sample
      drive(3, 2, 3);
      @(negedge clk);
      chk(err === 1'b0, "R7 flag clears next cycle", int'(err), 0);
      te = cyc;
      next_pulse(t);
      chk(t - te == 194, "R7 first period after recovery", t - te, 194);

      // R2: worked example A=63, B=891, P=32
      drive(2, 63, 891);
      next_pulse(t1);
      next_pulse(t2);
      chk(t2 - t1 == 28575, "R2 example A=63 B=891 P=32", t2 - t1, 28575);

      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

endmodule